// File: doc/BRIEF.md
# Clock-Synchronous Serial Transmit/Receive Unit

A register-mapped serial port for a small microcontroller subsystem. Software reaches four byte-wide registers over a minimal write/read bus: a data register (write fills the transmit buffer, read returns the last received byte), a status register, a control register and a baud-divider register. Frames are eight bits, shifted least significant bit first. The data line changes on the falling edge of the shift clock and is sampled on the rising edge. The shift clock is either generated internally from the system clock or taken from an external pin through a synchronizer.

A transmit buffer feeds a shift register. Two status flags report progress: buffer-empty and shift-complete. A control bit picks which of the two raises the single transmit-interrupt line. Turning the transmitter on sets both flags and raises the interrupt at once. Reception in this mode needs transmit and receive enabled and a dummy byte written. A serial-enable bit decides whether the TxD pin shows the shifter or a general port level. Shifting goes on inside the block either way.

Register map (bus_addr): 0 = data, 1 = status {bit2 rx_full, bit1 shift_done, bit0 buf_empty}, 2 = control {bit4 pin_serial, bit3 irq_on_done, bit2 ext_clk, bit1 rx_en, bit0 tx_en}, 3 = baud divider.

Top module: `ssio_top`

## Requirements
- R1: After reset, control, status and baud registers read 0, sclk_o is 1, sclk_oe is 1 and tx_irq is 0.
- R2: A 0-to-1 change of tx_en sets buf_empty and shift_done and pulses tx_irq one cycle after the control write, whatever irq_on_done holds.
- R3: A data write with tx_en=1 clears buf_empty after that edge. The shifter loads on the next edge and buf_empty returns to 1. With irq_on_done=0, tx_irq pulses at that load; with irq_on_done=1 it does not.
- R4: After a data write, shift_done still reads 1 in the following cycle and reads 0 one cycle later (two-stage clear).
- R5: With the internal clock and divider value B, each half period of SCLK lasts B+1 system cycles. Bit k (LSB first) appears on TxD at falling edge k, which falls 1+(2k+1)(B+1) cycles after the write edge, while sclk_o is low.
- R6: RxD is sampled at each rising SCLK edge. After the eighth, the data register reads the received byte and rx_full reads 1 when rx_en is set.
- R7: At the end of a frame (1+16(B+1) cycles after the write, internal clock), sclk_o is 1, TxD keeps the last bit, shift_done becomes 1, and tx_irq pulses when irq_on_done=1.
- R8: With pin_serial=0, txd_o follows port_val_i while shifting continues internally with unchanged timing. Setting pin_serial mid-frame puts the shifter's current bit on TxD.
- R9: With ext_clk=1, sclk_oe is 0 and a data write only arms the shifter. Edges on sclk_i, after synchronization, shift the frame.
- R10: Clearing only rx_en mid-frame lets the frame finish. Clearing tx_en and rx_en together aborts it: SCLK returns high and shift_done stays 0.
- R11: A baud-divider write has no effect while tx_en or rx_en is 1.
- R12: A data write with tx_en=0 is ignored: buf_empty keeps its value and no frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| rxd_i | input | 1 | Serial receive data |
| sclk_i | input | 1 | External shift clock |
| port_val_i | input | 1 | Port level shown on TxD when serial pin use is off |
| txd_o | output | 1 | Serial transmit data pin |
| sclk_o | output | 1 | Internal shift clock output |
| sclk_oe | output | 1 | Shift clock output enable (1 when internal clock) |
| tx_irq | output | 1 | Transmit interrupt request pulse |

## Verification
The bench builds the block with its defaults: eight-bit frames, an eight-bit divider and a two-stage clock synchronizer. It sweeps divider values 0 to 3 against several bit patterns. Each bit time and the completion cycle are computed as 1+(2k+1)(B+1) and 1+16(B+1). The small divider range keeps every bit position and every half-period length within a short run. A TxD-to-RxD loopback checks the received byte. Directed runs cover the external clock, the interrupt source choice, pin handover, partial and full disable, and the register locks.

// File: rtl/ssio_pkg.sv
`timescale 1ns/1ps
package ssio_pkg;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_STAT = 2'd1,
        REG_CTRL = 2'd2,
        REG_BAUD = 2'd3
    } reg_sel_e;

    // control register, bit 0 is tx_en
    typedef struct packed {
        logic pin_serial;
        logic irq_on_done;
        logic ext_clk;
        logic rx_en;
        logic tx_en;
    } ctrl_t;

    // status register, bit 0 is buf_empty
    typedef struct packed {
        logic rx_full;
        logic shift_done;
        logic buf_empty;
    } stat_t;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_FALL = 2'd1,
        EV_RISE = 2'd2
    } sclk_ev_e;

    // decide which shift-clock edge happens this cycle
    function automatic sclk_ev_e pick_edge(input logic ext, input logic sclk_now,
                                           input logic tick, input logic efall,
                                           input logic erise);
        if (ext) begin
            if (efall) return EV_FALL;
            if (erise) return EV_RISE;
            return EV_NONE;
        end
        if (tick) return sclk_now ? EV_FALL : EV_RISE;
        return EV_NONE;
    endfunction

endpackage

// File: rtl/ssio_baud_timer.sv
`timescale 1ns/1ps
module ssio_baud_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] reload,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= reload;
        end else if (run) begin
            if (cnt_q == '0) cnt_q <= reload;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/ssio_clk_sync.sv
`timescale 1ns/1ps
module ssio_clk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    output logic fall,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              level;

    assign level = sync_q[STAGES-1];
    assign fall  = prev_q && !level;
    assign rise  = !prev_q && level;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], sclk_i};
            prev_q <= level;
        end
    end
endmodule

// File: rtl/ssio_shift_core.sv
`timescale 1ns/1ps
module ssio_shift_core
    import ssio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              ext_clk,
    input  logic              irq_on_done,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    input  logic              ext_fall,
    input  logic              ext_rise,
    input  logic              rxd,
    output logic              busy,
    output logic              load_go,
    output logic              sclk_q,
    output logic              txd_q,
    output stat_t             stat,
    output logic [DATA_W-1:0] rx_data,
    output logic              irq
);
    localparam int CNT_W = $clog2(DATA_W);

    logic [DATA_W-1:0] buf_q, sh_q, sh_next;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic              busy_q, be_q, sd_q, rxf_q, irq_q, te_d_q, clr_p1_q;
    logic              both_off, last_bit;
    sclk_ev_e          ev;

    assign both_off = !tx_en && !rx_en;
    assign load_go  = !both_off && !busy_q && !be_q && tx_en && te_d_q;
    assign ev       = pick_edge(ext_clk, sclk_q, tick, ext_fall, ext_rise);
    assign sh_next  = {rxd, sh_q[DATA_W-1:1]};
    assign last_bit = (bit_cnt_q == CNT_W'(DATA_W - 1));

    assign busy = busy_q;
    assign irq  = irq_q;
    assign stat = '{rx_full: rxf_q, shift_done: sd_q, buf_empty: be_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q     <= '0;
            sh_q      <= '0;
            rx_data   <= '0;
            bit_cnt_q <= '0;
            busy_q    <= 1'b0;
            be_q      <= 1'b0;
            sd_q      <= 1'b0;
            rxf_q     <= 1'b0;
            irq_q     <= 1'b0;
            te_d_q    <= 1'b0;
            clr_p1_q  <= 1'b0;
            sclk_q    <= 1'b1;
            txd_q     <= 1'b1;
        end else begin
            irq_q    <= 1'b0;
            clr_p1_q <= 1'b0;
            te_d_q   <= tx_en;
            if (both_off) begin
                busy_q    <= 1'b0;
                sclk_q    <= 1'b1;
                bit_cnt_q <= '0;
            end else if (load_go) begin
                sh_q      <= buf_q;
                busy_q    <= 1'b1;
                be_q      <= 1'b1;
                bit_cnt_q <= '0;
                sclk_q    <= 1'b1;
                rxf_q     <= 1'b0;
                sd_q      <= 1'b0;
                if (!irq_on_done) irq_q <= 1'b1;
            end else if (busy_q) begin
                case (ev)
                    EV_FALL: begin
                        txd_q <= sh_q[0];
                        if (!ext_clk) sclk_q <= 1'b0;
                    end
                    EV_RISE: begin
                        sclk_q    <= 1'b1;
                        sh_q      <= sh_next;
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                        if (last_bit) begin
                            busy_q    <= 1'b0;
                            bit_cnt_q <= '0;
                            if (rx_en) begin
                                rx_data <= sh_next;
                                rxf_q   <= 1'b1;
                            end
                            if (be_q) begin
                                sd_q <= 1'b1;
                                if (irq_on_done) irq_q <= 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
            // transmitter switched on: both flags up, request raised
            if (tx_en && !te_d_q) begin
                be_q  <= 1'b1;
                sd_q  <= 1'b1;
                irq_q <= 1'b1;
            end
            if (wr_data && tx_en) begin
                buf_q    <= wdata;
                be_q     <= 1'b0;
                clr_p1_q <= 1'b1;
            end
            // second stage of the delayed shift_done clear
            if (clr_p1_q) sd_q <= 1'b0;
        end
    end

    // R4: shift_done is low two cycles after an accepted buffer write
    assert_done_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_data && tx_en) |=> ##1 !sd_q);

    // R7: whenever a frame ends or aborts, the shift clock is parked high
    assert_sclk_parks_high_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> sclk_q);

    // R9: the external clock mode never pulls the internal clock low
    assert_ext_no_drive_R9: assert property (@(posedge clk) disable iff (rst)
        (busy_q && ext_clk) |-> sclk_q);

    // R3: an interrupt pulse always comes with a raised flag
    assert_irq_has_flag_R3: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> (be_q || sd_q));
endmodule

// File: rtl/ssio_top.sv
`timescale 1ns/1ps
module ssio_top
    import ssio_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rxd_i,
    input  logic              sclk_i,
    input  logic              port_val_i,
    output logic              txd_o,
    output logic              sclk_o,
    output logic              sclk_oe,
    output logic              tx_irq
);
    localparam int CTRL_W = $bits(ctrl_t);
    localparam int STAT_W = $bits(stat_t);

    ctrl_t             ctrl_q;
    logic [DIV_W-1:0]  baud_q;
    stat_t             stat;
    logic [DATA_W-1:0] rx_data;
    logic              wr_data, busy, load_go, tick, ext_fall, ext_rise;
    logic              sclk_q, txd_q, irq;
    reg_sel_e          sel;

    assign sel     = reg_sel_e'(bus_addr);
    assign wr_data = bus_wr && (sel == REG_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            baud_q <= '0;
        end else if (bus_wr) begin
            if (sel == REG_CTRL)
                ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (sel == REG_BAUD && !ctrl_q.tx_en && !ctrl_q.rx_en)
                baud_q <= bus_wdata[DIV_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            REG_DATA: bus_rdata = rx_data;
            REG_STAT: bus_rdata[STAT_W-1:0] = stat;
            REG_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
            REG_BAUD: bus_rdata[DIV_W-1:0]  = baud_q;
            default:  bus_rdata = '0;
        endcase
    end

    ssio_baud_timer #(.DIV_W(DIV_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (busy && !ctrl_q.ext_clk),
        .restart (load_go),
        .reload  (baud_q),
        .tick    (tick)
    );

    ssio_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .sclk_i (sclk_i),
        .fall   (ext_fall),
        .rise   (ext_rise)
    );

    ssio_shift_core #(.DATA_W(DATA_W)) u_core (
        .clk         (clk),
        .rst         (rst),
        .tx_en       (ctrl_q.tx_en),
        .rx_en       (ctrl_q.rx_en),
        .ext_clk     (ctrl_q.ext_clk),
        .irq_on_done (ctrl_q.irq_on_done),
        .wr_data     (wr_data),
        .wdata       (bus_wdata),
        .tick        (tick),
        .ext_fall    (ext_fall),
        .ext_rise    (ext_rise),
        .rxd         (rxd_i),
        .busy        (busy),
        .load_go     (load_go),
        .sclk_q      (sclk_q),
        .txd_q       (txd_q),
        .stat        (stat),
        .rx_data     (rx_data),
        .irq         (irq)
    );

    assign txd_o   = ctrl_q.pin_serial ? txd_q : port_val_i;
    assign sclk_o  = sclk_q;
    assign sclk_oe = !ctrl_q.ext_clk;
    assign tx_irq  = irq;

    // R2: enabling the transmitter raises both flags and the request
    assert_enable_sets_flags_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q.tx_en) |=> (stat.buf_empty && stat.shift_done && tx_irq));

    // R11: the divider value is frozen while either direction is on
    assert_baud_locked_R11: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.tx_en || ctrl_q.rx_en) |=> $stable(baud_q));
endmodule

// File: tb/tb_ssio_top.sv
`timescale 1ns/1ps
module tb_ssio_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] bus_addr;
    logic       bus_wr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       rxd_drv, loop_on, sclk_i, port_val_i;
    logic       rxd_i, txd_o, sclk_o, sclk_oe, tx_irq;
    int         nchk = 0, nerr = 0, tnow = 0;
    logic [7:0] rv;

    localparam logic [1:0] A_DATA = 2'd0, A_STAT = 2'd1, A_CTRL = 2'd2, A_BAUD = 2'd3;

    assign rxd_i = loop_on ? txd_o : rxd_drv;

    always #2 clk = ~clk;

    ssio_top dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd_i(rxd_i),
        .sclk_i(sclk_i), .port_val_i(port_val_i), .txd_o(txd_o),
        .sclk_o(sclk_o), .sclk_oe(sclk_oe), .tx_irq(tx_irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: got %0h expected %0h (t=%0d)", tag, act, exp, tnow);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        tnow += n;
    endtask

    task automatic goto_t(input int t);
        if (t > tnow) step(t - tnow);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step(1);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    // full internal-clock frame with loopback, divider b, interrupt on completion
    task automatic run_int(input int b, input logic [7:0] d);
        logic [7:0] s;
        wr(A_CTRL, 8'h00);
        wr(A_BAUD, 8'(b));
        wr(A_CTRL, 8'h1B);
        step(1);
        rd(A_STAT, s);
        check("R2 flags after enable", int'(s[1:0]), 3);
        check("R2 irq after enable", int'(tx_irq), 1);
        wr(A_DATA, d);
        tnow = 0;
        rd(A_STAT, s);
        check("R3 buf_empty low after write", int'(s[0]), 0);
        check("R4 shift_done still high", int'(s[1]), 1);
        step(1);
        rd(A_STAT, s);
        check("R3 buf_empty back after load", int'(s[0]), 1);
        check("R4 shift_done cleared", int'(s[1]), 0);
        check("R3 no irq at load when source is done", int'(tx_irq), 0);
        for (int k = 0; k < 8; k++) begin
            goto_t(1 + (2*k + 1)*(b + 1));
            check("R5 txd bit", int'(txd_o), int'(d[k]));
            check("R5 sclk low", int'(sclk_o), 0);
        end
        goto_t(16*(b + 1));
        rd(A_STAT, s);
        check("R7 not done before last edge", int'(s[1]), 0);
        goto_t(1 + 16*(b + 1));
        rd(A_STAT, s);
        check("R7 shift_done set", int'(s[1]), 1);
        check("R7 sclk parked high", int'(sclk_o), 1);
        check("R7 txd holds last bit", int'(txd_o), int'(d[7]));
        check("R7 irq on completion", int'(tx_irq), 1);
        check("R6 rx_full", int'(s[2]), 1);
        rd(A_DATA, s);
        check("R6 received byte", int'(s), int'(d));
    endtask

    initial begin
        logic [7:0] pats [4];
        logic [7:0] dx, px;
        pats[0] = 8'h01; pats[1] = 8'h80; pats[2] = 8'hA5; pats[3] = 8'h3C;
        rst = 1'b1; bus_addr = 2'd0; bus_wr = 1'b0; bus_wdata = 8'h00;
        rxd_drv = 1'b0; loop_on = 1'b1; sclk_i = 1'b1; port_val_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step(1);

        // R1 reset state
        rd(A_STAT, rv); check("R1 status", int'(rv), 0);
        rd(A_CTRL, rv); check("R1 control", int'(rv), 0);
        rd(A_BAUD, rv); check("R1 baud", int'(rv), 0);
        check("R1 sclk_o", int'(sclk_o), 1);
        check("R1 sclk_oe", int'(sclk_oe), 1);
        check("R1 tx_irq", int'(tx_irq), 0);

        // sweep of divider values and patterns
        for (int b = 0; b < 4; b++)
            for (int p = 0; p < 4; p++)
                run_int(b, pats[p] ^ 8'(b * 8'h11));

        // R3 interrupt from buffer-empty
        wr(A_CTRL, 8'h00); wr(A_BAUD, 8'h00); wr(A_CTRL, 8'h13); step(1);
        wr(A_DATA, 8'h96); tnow = 0;
        check("R3 no irq before load", int'(tx_irq), 0);
        step(1);
        check("R3 irq at load", int'(tx_irq), 1);
        goto_t(17);
        rd(A_STAT, rv);
        check("R3 no irq at completion", int'(tx_irq), 0);
        check("R3 frame completes", int'(rv[1]), 1);

        // R11 divider locked while enabled
        wr(A_CTRL, 8'h00); wr(A_BAUD, 8'h00); wr(A_CTRL, 8'h1B); step(1);
        wr(A_BAUD, 8'h03);
        rd(A_BAUD, rv); check("R11 divider unchanged", int'(rv), 0);
        wr(A_DATA, 8'h5C); tnow = 0;
        goto_t(16); rd(A_STAT, rv); check("R11 timing uses old divider (early)", int'(rv[1]), 0);
        goto_t(17); rd(A_STAT, rv); check("R11 timing uses old divider", int'(rv[1]), 1);

        // R10 clear only rx_en: frame finishes
        wr(A_DATA, 8'hC3); tnow = 0;
        goto_t(5); wr(A_CTRL, 8'h19);
        goto_t(17); rd(A_STAT, rv);
        check("R10 partial disable completes", int'(rv[1]), 1);
        check("R10 last bit on txd", int'(txd_o), 1);

        // R10 clear both: abort
        wr(A_CTRL, 8'h1B); step(2);
        wr(A_DATA, 8'h3C); tnow = 0;
        goto_t(5); wr(A_CTRL, 8'h10);
        goto_t(17); rd(A_STAT, rv);
        check("R10 abort no completion", int'(rv[1]), 0);
        goto_t(30);
        check("R10 abort sclk high", int'(sclk_o), 1);

        // R12 data write ignored with tx_en off
        wr(A_DATA, 8'hAA); step(20);
        rd(A_STAT, rv);
        check("R12 status unchanged", int'(rv[2:0]), 1);
        check("R12 no clock activity", int'(sclk_o), 1);

        // R8 pin handover
        wr(A_CTRL, 8'h00); wr(A_BAUD, 8'h01); wr(A_CTRL, 8'h0B); step(1);
        port_val_i = 1'b1; loop_on = 1'b0; rxd_drv = 1'b0;
        wr(A_DATA, 8'h00); tnow = 0;
        goto_t(3); check("R8 port level on txd", int'(txd_o), 1);
        goto_t(4); wr(A_CTRL, 8'h1B);
        check("R8 shifter bit after enable", int'(txd_o), 0);
        goto_t(32); rd(A_STAT, rv); check("R8 timing kept (early)", int'(rv[1]), 0);
        goto_t(33); rd(A_STAT, rv); check("R8 internal shifting continued", int'(rv[1]), 1);

        // R9 external clock
        wr(A_CTRL, 8'h00); wr(A_CTRL, 8'h17); step(1);
        check("R9 sclk_oe off", int'(sclk_oe), 0);
        dx = 8'h6B; px = 8'hD2;
        wr(A_DATA, dx); tnow = 0;
        step(6); rd(A_STAT, rv);
        check("R9 armed, not started", int'(rv[1]), 0);
        for (int k = 0; k < 8; k++) begin
            sclk_i = 1'b0; rxd_drv = px[k];
            step(4);
            check("R9 txd bit on external clock", int'(txd_o), int'(dx[k]));
            sclk_i = 1'b1;
            step(4);
        end
        rd(A_STAT, rv);
        check("R9 external frame done", int'(rv[1]), 1);
        rd(A_DATA, rv);
        check("R9 external received byte", int'(rv), int'(px));

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule